// File: doc/BRIEF.md
# Per-Module Clock Gating Controller

This block hands out one clock enable and one gated clock to each of twenty peripheral modules. Two 32-bit control words are held in a small register file that software reads and writes over a simple single-cycle bus. Each implemented bit turns one module clock on or off.

The CPU power mode also acts on the enables. A three-state mode machine samples the `halt_in` and `sleep_in` inputs on every clock edge:

- **MODE_RUN**: neither input is set.
- **MODE_HALT**: `halt_in` is set and `sleep_in` is clear.
- **MODE_SLEEP**: `sleep_in` is set. SLEEP wins over HALT.

Every transition between any two states is taken directly on the edge that samples the inputs: RUN→HALT, RUN→SLEEP, HALT→RUN, HALT→SLEEP, SLEEP→RUN and SLEEP→HALT.

Modules fall into two classes:

- **Plain modules** follow only their bit, and ignore HALT.
- **Halt-gated modules** run whenever the CPU runs. They lose their clock while the CPU is halted, but only if their bit is 0.

SLEEP removes every clock, whatever the register bits hold. Each gated clock comes from a latch-based cell whose latch is open while the source clock is low. An enable change can therefore never shorten a high phase.

Top module: `clk_gate_ctrl`

## Requirements
- R1: After reset, word 0 (offset 0x0) reads 0x0000_0088 and word 1 (offset 0x4) reads 0x3F01_FA5E, and every implemented enable is 1. Enable/clock index i is 32×word+bit.
- R2: In RUN, the enable of a plain module equals its stored bit from the cycle after the write. Plain bits are word 0 bit 3 and word 1 bits 1, 2, 3, 4, 6, 9, 11, 12, 13, 14, 15 and 16. Writing 0 stops the clock and writing 1 restores it.
- R3: Bits outside the implemented set read 0 and ignore writes. Writes to offsets other than 0x0 and 0x4 change nothing, and reads from them return 0. The offset is the 4-bit `bus_addr`.
- R4: Plain enables keep following their bits while in HALT.
- R5: A halt-gated enable is 1 in RUN whatever its bit holds. In HALT it equals its bit. Halt-gated bits are word 0 bit 7 and word 1 bits 24–29.
- R6: In SLEEP every enable is 0, including when `halt_in` is also set.
- R7: A change of `halt_in` or `sleep_in` sampled at a clock edge reaches the enables right after that edge, and not earlier.
- R8: During each high phase of `clk`, every gated clock equals the enable its module held just before the preceding rising edge. Unimplemented gated clocks stay 0.
- R9: Reads return the stored bits, not the effective enables, including during HALT and SLEEP. Writes made during SLEEP are stored and take effect on wake-up.
- R10: `bus_rdata` is loaded on the edge that takes a read (`bus_sel`=1, `bus_wr`=0) and holds its value otherwise.
- R11: Unimplemented enable outputs are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_in | input | 1 | CPU halted, synchronous to clk |
| sleep_in | input | 1 | CPU asleep, synchronous to clk |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Byte offset of the control word |
| bus_wdata | input | REG_W (32) | Write data |
| bus_rdata | output | REG_W (32) | Registered read data |
| mod_clk_en | output | 2×REG_W (64) | Effective clock enable per module |
| mod_gclk | output | 2×REG_W (64) | Gated clock per module |

## Verification
The bench goes after the halt-gated class: it clears those bits and checks that the clocks still run in RUN and stop only in HALT. A design that folded HALT into the plain rule would kill those clocks as soon as the bit is written, or would stop plain modules on halt.

It raises SLEEP together with HALT, and writes during SLEEP. A design with the wrong priority would leave halt-gated clocks running. A design that read back effective enables would return zeros.

It writes all ones, and also writes to undecoded offsets. A design with loose masking or decoding would expose phantom bits or corrupt a real word.

Every high phase of each gated clock is compared against the enable seen before the edge. This catches a gating cell with the latch on the wrong phase or no latch at all.

// File: rtl/clk_gate_pkg.sv
package clk_gate_pkg;

    localparam int REG_W_DEF    = 32;
    localparam int NUM_REGS_DEF = 2;
    localparam int ADDR_W_DEF   = 4;

    // index = 32*word + bit
    localparam logic [63:0] PLAIN_MASK_DEF = {32'h0001_FA5E, 32'h0000_0008};
    localparam logic [63:0] HALT_MASK_DEF  = {32'h3F00_0000, 32'h0000_0080};

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_HALT  = 2'd1,
        MODE_SLEEP = 2'd2
    } pmode_e;

endpackage

// File: rtl/clk_gate_regbank.sv
module clk_gate_regbank #(
    parameter int REG_W    = 32,
    parameter int NUM_REGS = 2,
    parameter int ADDR_W   = 4,
    parameter logic [NUM_REGS*REG_W-1:0] IMPL_MASK = '1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_sel,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [REG_W-1:0]          bus_wdata,
    output logic [REG_W-1:0]          bus_rdata,
    output logic [NUM_REGS*REG_W-1:0] ctrl_bits
);
    localparam int BYTES = REG_W / 8;

    logic [NUM_REGS-1:0] hit;
    logic [REG_W-1:0]    rd_mux;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
        localparam logic [REG_W-1:0] WMASK = IMPL_MASK[r*REG_W +: REG_W];
        logic [REG_W-1:0] word_q;

        assign hit[r] = (bus_addr == ADDR_W'(r * BYTES));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= WMASK;
            end else if (bus_sel && bus_wr && hit[r]) begin
                word_q <= bus_wdata & WMASK;
            end
        end

        assign ctrl_bits[r*REG_W +: REG_W] = word_q;
    end

    always_comb begin
        rd_mux = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (hit[r]) rd_mux = rd_mux | ctrl_bits[r*REG_W +: REG_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_sel && !bus_wr) begin
            bus_rdata <= rd_mux;
        end
    end

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_foreign_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(bus_sel && bus_wr && (hit == '0))) |-> $stable(ctrl_bits));

    assert_rdata_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(bus_sel && !bus_wr)) |-> $stable(bus_rdata));

endmodule

// File: rtl/clk_gate_mode_fsm.sv
module clk_gate_mode_fsm
    import clk_gate_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   halt_in,
    input  logic   sleep_in,
    output pmode_e mode
);
    pmode_e mode_q, mode_d;

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_RUN, MODE_HALT, MODE_SLEEP: begin
                if (sleep_in)     mode_d = MODE_SLEEP;
                else if (halt_in) mode_d = MODE_HALT;
                else              mode_d = MODE_RUN;
            end
            default: mode_d = MODE_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_RUN;
        else        mode_q <= mode_d;
    end

    assign mode = mode_q;

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_sleep_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(sleep_in)) |-> (mode == MODE_SLEEP));

endmodule

// File: rtl/clk_gate_enables.sv
module clk_gate_enables
    import clk_gate_pkg::*;
#(
    parameter int CTRL_W = 64,
    parameter logic [CTRL_W-1:0] PLAIN_MASK = '0,
    parameter logic [CTRL_W-1:0] HALT_MASK  = '0
) (
    input  pmode_e            mode,
    input  logic [CTRL_W-1:0] ctrl_bits,
    output logic [CTRL_W-1:0] clk_en
);
    logic in_sleep, in_halt;
    assign in_sleep = (mode == MODE_SLEEP);
    assign in_halt  = (mode == MODE_HALT);

    for (genvar i = 0; i < CTRL_W; i++) begin : g_bit
        if (PLAIN_MASK[i]) begin : g_plain
            assign clk_en[i] = ctrl_bits[i] & ~in_sleep;
        end else if (HALT_MASK[i]) begin : g_auto
            assign clk_en[i] = ~in_sleep & (ctrl_bits[i] | ~in_halt);
        end else begin : g_none
            // the register bank holds unimplemented bits at zero
            assign clk_en[i] = ctrl_bits[i];
        end
    end

endmodule

// File: rtl/clk_gate_cell.sv
module clk_gate_cell (
    input  logic clk_in,
    input  logic en,
    output logic gclk
);
    logic en_lat;

    always_latch begin
        if (!clk_in) en_lat = en;
    end

    assign gclk = clk_in & en_lat;

endmodule

// File: rtl/clk_gate_ctrl.sv
module clk_gate_ctrl
    import clk_gate_pkg::*;
#(
    parameter int REG_W    = REG_W_DEF,
    parameter int NUM_REGS = NUM_REGS_DEF,
    parameter int ADDR_W   = ADDR_W_DEF,
    parameter logic [NUM_REGS*REG_W-1:0] PLAIN_MASK = PLAIN_MASK_DEF,
    parameter logic [NUM_REGS*REG_W-1:0] HALT_MASK  = HALT_MASK_DEF
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      halt_in,
    input  logic                      sleep_in,
    input  logic                      bus_sel,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [REG_W-1:0]          bus_wdata,
    output logic [REG_W-1:0]          bus_rdata,
    output logic [NUM_REGS*REG_W-1:0] mod_clk_en,
    output logic [NUM_REGS*REG_W-1:0] mod_gclk
);
    localparam int CTRL_W = NUM_REGS * REG_W;
    localparam logic [CTRL_W-1:0] IMPL_MASK = PLAIN_MASK | HALT_MASK;

    logic [CTRL_W-1:0] ctrl_bits;
    pmode_e            mode;

    clk_gate_regbank #(
        .REG_W(REG_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .IMPL_MASK(IMPL_MASK)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ctrl_bits(ctrl_bits)
    );

    clk_gate_mode_fsm u_mode (
        .clk(clk), .rst_n(rst_n), .halt_in(halt_in), .sleep_in(sleep_in), .mode(mode)
    );

    clk_gate_enables #(
        .CTRL_W(CTRL_W), .PLAIN_MASK(PLAIN_MASK), .HALT_MASK(HALT_MASK)
    ) u_en (
        .mode(mode), .ctrl_bits(ctrl_bits), .clk_en(mod_clk_en)
    );

    for (genvar i = 0; i < CTRL_W; i++) begin : g_gate
        if (IMPL_MASK[i]) begin : g_cell
            clk_gate_cell u_cell (.clk_in(clk), .en(mod_clk_en[i]), .gclk(mod_gclk[i]));
        end else begin : g_tie
            assign mod_gclk[i] = 1'b0;
        end
    end

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_sleep_stops_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(sleep_in)) |-> (mod_clk_en == '0));

    assert_halt_spares_plain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(halt_in && !sleep_in))
            |-> ((mod_clk_en & PLAIN_MASK) == (ctrl_bits & PLAIN_MASK)));

    assert_run_enables_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(!halt_in && !sleep_in))
            |-> (mod_clk_en == ((ctrl_bits & PLAIN_MASK) | HALT_MASK)));

    assert_unimpl_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_clk_en & ~IMPL_MASK) == '0);

endmodule

// File: tb/clk_gate_ctrl_bench.sv
`timescale 1ns/1ps
module clk_gate_ctrl_bench;

    localparam logic [63:0] PLAIN = {32'h0001_FA5E, 32'h0000_0008};
    localparam logic [63:0] HALTM = {32'h3F00_0000, 32'h0000_0080};
    localparam logic [63:0] IMPL  = PLAIN | HALTM;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        halt_in = 1'b0, sleep_in = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] mod_clk_en, mod_gclk;

    always #10 clk = ~clk;

    clk_gate_ctrl u_clk_gate_ctrl (
        .clk(clk), .rst_n(rst_n), .halt_in(halt_in), .sleep_in(sleep_in),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mod_clk_en(mod_clk_en), .mod_gclk(mod_gclk)
    );

    typedef struct {
        int          kind;   // 0 enables, 1 read data
        logic [63:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    int n_vec = 0;
    int n_err = 0;

    // reference model
    logic [63:0] m_ctrl = IMPL;
    bit m_halt = 0, m_sleep = 0;

    function automatic logic [63:0] model_en();
        logic [63:0] p, a;
        p = m_ctrl & PLAIN & {64{~m_sleep}};
        a = m_sleep ? 64'd0 : (HALTM & (m_ctrl | {64{~m_halt}}));
        return p | a;
    endfunction

    function automatic logic [31:0] model_rd(input logic [3:0] a);
        if (a == 4'h0) return m_ctrl[31:0];
        if (a == 4'h4) return m_ctrl[63:32];
        return 32'd0;
    endfunction

    task automatic step(input bit sel, input bit wr, input logic [3:0] a,
                        input logic [31:0] d, input bit h, input bit s, input string req);
        item_t it;
        @(negedge clk); #1;
        bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = d;
        halt_in = h; sleep_in = s;
        @(posedge clk); #1;
        if (sel && !wr) begin
            it.kind = 1; it.exp = {32'd0, model_rd(a)}; it.req = req;
            q.push_back(it);
        end
        if (sel && wr && a == 4'h0) m_ctrl[31:0]  = d & IMPL[31:0];
        if (sel && wr && a == 4'h4) m_ctrl[63:32] = d & IMPL[63:32];
        m_halt = h; m_sleep = s;
        it.kind = 0; it.exp = model_en(); it.req = req;
        q.push_back(it);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input bit h, input bit s,
                      input string req);
        step(1, 1, a, d, h, s, req);
    endtask

    task automatic rd(input logic [3:0] a, input bit h, input bit s, input string req);
        step(1, 0, a, 32'd0, h, s, req);
    endtask

    task automatic idle(input bit h, input bit s, input string req);
        step(0, 0, 4'h0, 32'd0, h, s, req);
    endtask

    // monitor
    initial begin
        item_t it;
        logic [63:0] act;
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                it = q.pop_front();
                act = (it.kind == 0) ? mod_clk_en : {32'd0, bus_rdata};
                n_vec++;
                if (act !== it.exp) begin
                    n_err++;
                    $display("FAIL %s %s: actual %h expected %h", it.req,
                             it.kind == 0 ? "enables" : "rdata", act, it.exp);
                end
            end
        end
    end

    // gated clock monitor
    logic [63:0] en_before_edge;
    bit gclk_armed = 0;
    always @(negedge clk) en_before_edge <= mod_clk_en;
    initial begin
        forever begin
            @(posedge clk); #5;
            if (gclk_armed) begin
                n_vec++;
                if (mod_gclk !== (en_before_edge & IMPL)) begin
                    n_err++;
                    $display("FAIL R8 gclk high phase: actual %h expected %h",
                             mod_gclk, en_before_edge & IMPL);
                end
            end
        end
    end

    bit done = 0;
    initial begin
        #(200000 * 20);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        gclk_armed = 1;

        // R1 reset state
        idle(0, 0, "R1");
        rd(4'h0, 0, 0, "R1");
        rd(4'h4, 0, 0, "R1");

        // R2, R5: clear word 1 in RUN; halt-gated stay on
        wr(4'h4, 32'h0, 0, 0, "R2 R5");
        rd(4'h4, 0, 0, "R2");
        wr(4'h0, 32'h0, 0, 0, "R2 R5");
        wr(4'h0, 32'h8, 0, 0, "R2");

        // R3: all ones, foreign offsets
        wr(4'h4, 32'hFFFF_FFFF, 0, 0, "R3");
        rd(4'h4, 0, 0, "R3");
        wr(4'h8, 32'h0, 0, 0, "R3");
        wr(4'hC, 32'h0, 0, 0, "R3");
        wr(4'h2, 32'h0, 0, 0, "R3");
        rd(4'h8, 0, 0, "R3");
        rd(4'h0, 0, 0, "R3");
        rd(4'h4, 0, 0, "R3");

        // R2: walk each plain bit of both words low then high
        for (int b = 0; b < 64; b++) begin
            if (PLAIN[b]) begin
                if (b < 32) wr(4'h0, IMPL[31:0] & ~(32'd1 << b), 0, 0, "R2");
                else        wr(4'h4, IMPL[63:32] & ~(32'd1 << (b - 32)), 0, 0, "R2");
            end
        end
        wr(4'h0, IMPL[31:0], 0, 0, "R2");
        wr(4'h4, IMPL[63:32], 0, 0, "R2");

        // R4, R5, R7: mixed pattern through HALT
        wr(4'h0, 32'h0000_0008, 0, 0, "R5");
        wr(4'h4, 32'h2A01_0A14, 0, 0, "R4 R5");
        idle(1, 0, "R4 R5 R7");
        idle(1, 0, "R4 R5");
        rd(4'h4, 1, 0, "R9");
        wr(4'h4, 32'h1500_F042, 1, 0, "R4 R5");
        idle(0, 0, "R5 R7");
        idle(1, 0, "R5 R7");

        // R6, R9: SLEEP with and without HALT
        idle(0, 1, "R6 R7");
        idle(1, 1, "R6");
        rd(4'h0, 1, 1, "R9");
        rd(4'h4, 0, 1, "R9");
        wr(4'h4, 32'h0000_0042, 0, 1, "R6 R9");
        rd(4'h4, 0, 1, "R9");
        idle(1, 0, "R7 R9");
        idle(0, 0, "R7 R9");
        idle(0, 0, "R10");
        rd(4'h0, 0, 0, "R10");
        wr(4'h0, 32'h0, 0, 0, "R10");
        idle(0, 0, "R10 R11");
        idle(0, 0, "R10");

        // R8 keeps running on every high phase above
        repeat (2) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

endmodule